// File: doc/BRIEF.md
# Conflict-Allocated Instruction Cache

This block sits next to an instruction sequencer whose program memory is shared between instruction fetches and data transfers. It keeps copies of a few instructions, but only those whose fetch ran into a data transfer on the program-memory bus. When the same address is fetched again, the cache supplies the instruction in the same cycle. Program memory is then free for the data transfer, so an instruction, a program-memory operand and a data-memory operand can all move in one cycle.

The cache is two-way set-associative with 16 sets (32 instructions in total). The low four address bits pick the set and the rest of the address is kept as the tag. A fetch that misses with no bus conflict never allocates. A conflicting miss is remembered, and in the next cycle the instruction that memory returns is written into the chosen way. One recency bit per set picks the way to replace. A flush input clears every line in one cycle, and an enable input turns the cache off.

Top module: `selective_icache`

## Requirements
- R1: After reset every line is invalid, so `hit` is 0 for any fetch until a fill has happened.
- R2: A fetch that misses while `bus_conflict` is 0 allocates nothing, so a later fetch of the same address still misses.
- R3: A fetch that misses with `bus_conflict` 1 in cycle t causes the `fill_instr` value presented in cycle t+1 to be stored. From cycle t+2 on, a fetch of that address hits and returns that value.
- R4: A hit is reported combinationally in the cycle the address is presented, with the stored instruction on `hit_instr`. When `fetch_valid` is 0, `hit` is 0.
- R5: Two addresses with the same low four bits (the set index) and different upper bits are resident at the same time.
- R6: When both ways of a set are valid, a fill replaces the way that was not touched most recently, where a hit or a fill counts as a touch.
- R7: When a set has an invalid way, a fill uses it, taking way 0 before way 1.
- R8: A cycle with `flush` 1 invalidates every line by the next cycle and cancels a fill due in that cycle, so the address is not resident afterwards.
- R9: While `cache_en` is 0, `hit` is 0 and no allocation is made. This covers a conflicting fetch made while disabled and a fill due in a disabled cycle. Lines already resident survive and hit again once the cache is enabled.
- R10: A fetch that hits never refills its set. A conflicting fetch of the address whose fill is being written in that cycle does not allocate a second copy, so an address is never resident in both ways.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cache_en | input | 1 | 1 enables lookups and allocation |
| flush | input | 1 | 1 clears all valid bits |
| fetch_valid | input | 1 | A fetch is presented this cycle |
| fetch_addr | input | ADDR_W | Instruction address of the fetch |
| bus_conflict | input | 1 | The fetch collides with a program-memory data transfer |
| fill_instr | input | INSTR_W | Instruction returned by memory for the previous cycle's conflicting fetch |
| hit | output | 1 | The fetch is served from the cache |
| hit_instr | output | INSTR_W | Cached instruction on a hit, zero otherwise |

## Verification
The embedded properties are checked on every cycle. They cover four rules: an address never matches in both ways, a fill only follows a conflicting fetch that was not a hit, a just-written address hits in the following cycle, and a flush cycle is always followed by a miss. The bench's scenarios are needed for the rest. Replacement order depends on a history of hits and fills across several cycles, which the scenarios build up and then observe. The same holds for the absence of allocation after non-conflicting or disabled fetches, the survival of lines across a disabled period, and the returned instruction values.

// File: rtl/sic_pkg.sv
package sic_pkg;

  typedef enum logic {WAY0 = 1'b0, WAY1 = 1'b1} way_e;

  // An empty way is taken before the recency bit is consulted.
  function automatic way_e pick_victim(logic v0, logic v1, logic lru_way);
    if (!v0) return WAY0;
    if (!v1) return WAY1;
    return way_e'(lru_way);
  endfunction

  // After a touch the other way becomes the one to replace.
  function automatic logic next_lru(way_e touched);
    return ~touched;
  endfunction

endpackage

// File: rtl/sic_way.sv
module sic_way #(
  parameter int ADDR_W   = 24,
  parameter int INSTR_W  = 48,
  parameter int NUM_SETS = 16,
  localparam int IDX_W   = $clog2(NUM_SETS),
  localparam int TAG_W   = ADDR_W - IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inv_all,
  input  logic [IDX_W-1:0]   rd_idx,
  input  logic [TAG_W-1:0]   rd_tag,
  output logic               match,
  output logic [INSTR_W-1:0] rd_data,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [TAG_W-1:0]   wr_tag,
  input  logic [INSTR_W-1:0] wr_data,
  output logic               wr_valid
);

  logic [NUM_SETS-1:0] valid_q;
  logic [TAG_W-1:0]    tag_q  [NUM_SETS];
  logic [INSTR_W-1:0]  data_q [NUM_SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       valid_q <= '0;
    else if (inv_all) valid_q <= '0;
    else if (wr_en)   valid_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      data_q[wr_idx] <= wr_data;
    end
  end

  assign match    = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
  assign rd_data  = data_q[rd_idx];
  assign wr_valid = valid_q[wr_idx];

endmodule

// File: rtl/sic_lru.sv
module sic_lru
  import sic_pkg::*;
#(
  parameter int NUM_SETS = 16,
  localparam int IDX_W   = $clog2(NUM_SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  input  way_e             touch_way,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  way_e             fill_way,
  output logic             lru_way
);

  logic [NUM_SETS-1:0] lru_q;

  // A fill in the same set as a hit is written last and so wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lru_q <= '0;
    else begin
      if (touch_en) lru_q[touch_idx] <= next_lru(touch_way);
      if (fill_en)  lru_q[fill_idx]  <= next_lru(fill_way);
    end
  end

  assign lru_way = lru_q[fill_idx];

endmodule

// File: rtl/selective_icache.sv
module selective_icache
  import sic_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int INSTR_W  = 48,
  parameter int NUM_SETS = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cache_en,
  input  logic               flush,
  input  logic               fetch_valid,
  input  logic [ADDR_W-1:0]  fetch_addr,
  input  logic               bus_conflict,
  input  logic [INSTR_W-1:0] fill_instr,
  output logic               hit,
  output logic [INSTR_W-1:0] hit_instr
);

  localparam int IDX_W = $clog2(NUM_SETS);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int WAYS  = 2;

  function automatic logic [IDX_W-1:0] idx_of(logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:IDX_W];
  endfunction

  logic [WAYS-1:0]    way_match;
  logic [WAYS-1:0]    way_valid_at_fill;
  logic [INSTR_W-1:0] way_data [WAYS];
  logic [WAYS-1:0]    way_we;

  logic              fill_pend_q;
  logic [ADDR_W-1:0] fill_addr_q;
  logic              lru_way;
  way_e              victim;
  way_e              hit_way;
  logic              lookup_hit;
  logic              same_as_fill;
  logic              alloc_req;
  logic              fill_we;

  // Named internal events
  assign lookup_hit   = cache_en && fetch_valid && (|way_match);
  assign hit_way      = way_match[1] ? WAY1 : WAY0;
  assign same_as_fill = fill_pend_q && (fill_addr_q == fetch_addr);
  assign alloc_req    = cache_en && fetch_valid && bus_conflict && !lookup_hit && !same_as_fill;
  assign fill_we      = fill_pend_q && cache_en && !flush;
  assign victim       = pick_victim(way_valid_at_fill[0], way_valid_at_fill[1], lru_way);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_pend_q <= 1'b0;
      fill_addr_q <= '0;
    end else begin
      fill_pend_q <= alloc_req;
      if (alloc_req) fill_addr_q <= fetch_addr;
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign way_we[w] = fill_we && (victim == way_e'(w));
    sic_way #(
      .ADDR_W  (ADDR_W),
      .INSTR_W (INSTR_W),
      .NUM_SETS(NUM_SETS)
    ) way_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .inv_all (flush),
      .rd_idx  (idx_of(fetch_addr)),
      .rd_tag  (tag_of(fetch_addr)),
      .match   (way_match[w]),
      .rd_data (way_data[w]),
      .wr_en   (way_we[w]),
      .wr_idx  (idx_of(fill_addr_q)),
      .wr_tag  (tag_of(fill_addr_q)),
      .wr_data (fill_instr),
      .wr_valid(way_valid_at_fill[w])
    );
  end

  sic_lru #(.NUM_SETS(NUM_SETS)) lru_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .touch_en (lookup_hit),
    .touch_idx(idx_of(fetch_addr)),
    .touch_way(hit_way),
    .fill_en  (fill_we),
    .fill_idx (idx_of(fill_addr_q)),
    .fill_way (victim),
    .lru_way  (lru_way)
  );

  assign hit       = lookup_hit;
  assign hit_instr = lookup_hit ? way_data[hit_way] : '0;

  // Assertions
  AST_NO_DUP_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(way_match)) else $error("address resident in both ways"); // R10

  AST_FILL_AFTER_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
    (|way_we) |-> $past(fetch_valid && bus_conflict && !hit)) else $error("fill without conflicting miss"); // R3

  AST_FILL_HITS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(|way_we) && cache_en && fetch_valid && (fetch_addr == $past(fill_addr_q))) |-> hit)
    else $error("filled address missed"); // R3

  AST_FLUSH_MISSES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !hit) else $error("hit after flush"); // R8

endmodule

// File: tb/selective_icache_tb.sv
module selective_icache_tb_top;

  localparam int AW = 24;
  localparam int IW = 48;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cache_en = 1'b1;
  logic          flush = 1'b0;
  logic          fetch_valid = 1'b0;
  logic [AW-1:0] fetch_addr = '0;
  logic          bus_conflict = 1'b0;
  logic [IW-1:0] fill_instr = '0;
  logic          hit;
  logic [IW-1:0] hit_instr;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  typedef struct {
    logic          eh;
    logic [IW-1:0] ei;
    string         tag;
  } exp_t;

  exp_t exp_q[$];

  always #2 clk = ~clk;

  selective_icache #(.ADDR_W(AW), .INSTR_W(IW), .NUM_SETS(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .cache_en(cache_en), .flush(flush),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .bus_conflict(bus_conflict),
    .fill_instr(fill_instr), .hit(hit), .hit_instr(hit_instr)
  );

  // Addresses: A, B, C share set 3; D, E share set 5.
  localparam logic [AW-1:0] A = 24'h000013, B = 24'h000123, C = 24'h000243;
  localparam logic [AW-1:0] D = 24'h000035, E = 24'h000145, F = 24'h000077;
  localparam logic [AW-1:0] G = 24'h000088, H = 24'h000099;
  localparam logic [IW-1:0] IA = 48'hA1A1_0000_0001, IB = 48'hB2B2_0000_0002;
  localparam logic [IW-1:0] IC = 48'hC3C3_0000_0003, ID = 48'hD4D4_0000_0004;
  localparam logic [IW-1:0] IE = 48'hE5E5_0000_0005, IX = 48'h5A5A_5A5A_5A5A;
  localparam logic [IW-1:0] IY = 48'h7777_0000_7777;

  // Driver: presents one cycle of stimulus and queues the expected outcome.
  task automatic step(input logic v, input logic [AW-1:0] a, input logic c,
                      input logic [IW-1:0] m, input logic eh,
                      input logic [IW-1:0] ei, input string tag);
    @(posedge clk); #1;
    fetch_valid  = v;
    fetch_addr   = a;
    bus_conflict = c;
    fill_instr   = m;
    exp_q.push_back('{eh, ei, tag});
  endtask

  // Monitor: compares at the falling edge, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (hit !== e.eh || (e.eh && hit_instr !== e.ei)) begin
        errors++;
        $display("FAIL %s: hit=%0b instr=%h expected hit=%0b instr=%h",
                 e.tag, hit, hit_instr, e.eh, e.ei);
      end
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    fetch_valid = 1'b1;
    fetch_addr  = A;
    #9;
    checks++;
    if (hit !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: hit=%0b expected 0", hit);
    end
    @(negedge clk); rst_n = 1'b1;

    step(1, A, 0, '0, 0, '0, "R1 empty after reset");
    // R2: non-conflicting misses never allocate
    step(1, D, 0, '0, 0, '0, "R2 first miss");
    step(0, 0, 0, IX, 0, '0, "R2 idle");
    step(1, D, 0, '0, 0, '0, "R2 still miss");
    // R3/R7: conflicting miss fills way 0 of set 3
    step(1, A, 1, '0, 0, '0, "R3 conflict miss");
    step(0, 0, 0, IA, 0, '0, "R3 fill cycle");
    step(1, A, 0, '0, 1, IA, "R3 hit after fill");
    step(0, A, 0, '0, 0, '0, "R4 no fetch no hit");
    // R5/R7: B goes to the empty way of the same set
    step(1, B, 1, '0, 0, '0, "R5 conflict miss B");
    step(0, 0, 0, IB, 0, '0, "R5 fill B");
    step(1, B, 0, '0, 1, IB, "R5 B resident");
    step(1, A, 0, '0, 1, IA, "R5 A resident");
    // R6: A touched last, so C replaces B
    step(1, C, 1, '0, 0, '0, "R6 conflict miss C");
    step(0, 0, 0, IC, 0, '0, "R6 fill C");
    step(1, C, 0, '0, 1, IC, "R6 C resident");
    step(1, A, 0, '0, 1, IA, "R6 A kept");
    step(1, B, 0, '0, 0, '0, "R6 B evicted");
    // R10: a conflicting hit does not refill
    step(1, A, 1, '0, 1, IA, "R10 conflicting hit");
    step(0, 0, 0, IX, 0, '0, "R10 idle after hit");
    step(1, C, 0, '0, 1, IC, "R10 C not overwritten");
    step(1, A, 0, '0, 1, IA, "R10 A unchanged");
    // R10: conflicting refetch during its own fill adds no second copy
    step(1, D, 1, '0, 0, '0, "R10 conflict miss D");
    step(1, D, 1, ID, 0, '0, "R10 refetch during fill");
    step(0, 0, 0, IY, 0, '0, "R10 idle");
    step(1, D, 0, '0, 1, ID, "R10 D resident");
    step(1, E, 1, '0, 0, '0, "R10 conflict miss E");
    step(0, 0, 0, IE, 0, '0, "R10 fill E");
    step(1, E, 0, '0, 1, IE, "R10 E resident");
    step(1, D, 0, '0, 1, ID, "R10 D single copy");
    // R9: disabled cache neither hits nor allocates
    @(posedge clk); #1; cache_en = 1'b0;
    exp_q.push_back('{1'b0, '0, "R9 transition"});
    step(1, A, 0, '0, 0, '0, "R9 no hit while disabled");
    step(1, F, 1, '0, 0, '0, "R9 conflict while disabled");
    step(0, 0, 0, IX, 0, '0, "R9 idle disabled");
    @(posedge clk); #1; cache_en = 1'b1; fetch_valid = 1'b0;
    exp_q.push_back('{1'b0, '0, "R9 reenable"});
    step(1, F, 0, '0, 0, '0, "R9 F not allocated");
    step(1, A, 0, '0, 1, IA, "R9 A survives disable");
    step(1, G, 1, '0, 0, '0, "R9 conflict miss G");
    @(posedge clk); #1; cache_en = 1'b0; fetch_valid = 1'b0; fill_instr = IX;
    exp_q.push_back('{1'b0, '0, "R9 fill cycle disabled"});
    @(posedge clk); #1; cache_en = 1'b1;
    exp_q.push_back('{1'b0, '0, "R9 reenable"});
    step(1, G, 0, '0, 0, '0, "R9 dropped fill");
    // R8: flush clears everything and cancels a due fill
    step(1, H, 1, '0, 0, '0, "R8 conflict miss H");
    @(posedge clk); #1; flush = 1'b1; fetch_valid = 1'b0; fill_instr = IX;
    exp_q.push_back('{1'b0, '0, "R8 flush cycle"});
    @(posedge clk); #1; flush = 1'b0;
    exp_q.push_back('{1'b0, '0, "R8 after flush"});
    step(1, A, 0, '0, 0, '0, "R8 A cleared");
    step(1, C, 0, '0, 0, '0, "R8 C cleared");
    step(1, E, 0, '0, 0, '0, "R8 E cleared");
    step(1, H, 0, '0, 0, '0, "R8 H fill cancelled");
    step(0, 0, 0, '0, 0, '0, "drain");

    @(posedge clk); @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule